// File: doc/BRIEF.md
# Register-Programmed Audio Routing Crossbar

This block is a two-sided switch for serial audio signals. On one side sit five external audio ports. Each port carries a bit clock, a frame sync and two serial data lines. On the other side sit three internal audio controllers. A small memory-mapped register bus configures the routing. Each external port has a control word that names its source. The source is either one of the controllers or another external port. The same word also holds a link-master flag and a transmit flag for each of the port's two data lines.

Each controller has a selection word that names three ports: one supplies its bit clock and frame sync, and one each supplies its two data inputs. Several controllers may name the same port, so a single port can feed all of them at once. All routing is combinational from the register contents. The switch never judges whether a configuration makes sense: whatever is programmed is applied as written.

The block has no sequencing logic of its own. Its only state is the configuration words and the registered read data. The bus side acts as a two-phase exchange: a write or read strobe is sampled on one rising edge, and its effect is visible right after that edge.

Top module: `audio_xbar`

## Requirements
- R1: Port control words sit at byte addresses 0x00, 0x04, 0x08, 0x0C and 0x10, for ports 0 to 4. In each word, bits 4:0 are the source code, bit 31 is the link-master flag, bit 30 is the transmit flag of data line 1, and bit 29 is the transmit flag of data line 2.
- R2: Controller selection words sit at byte addresses 0x40, 0x44 and 0x48, for controllers 0 to 2. In each word, bits 3:0 pick the clock/frame port, bits 27:24 pick the data line 1 port, and bits 31:28 pick the data line 2 port. Port codes 0 to 4 mean ports 0 to 4.
- R3: After reset, ports 0 to 2 have source codes 0 to 2 and ports 3 and 4 have source code 31. All port flags are 0, every controller field is 0, and the read data is 0.
- R4: A port whose source code c is 0, 1 or 2 drives controller c's clock and frame out of the port, and its clock output enable is 1.
- R5: A port whose source code is 16+q (q from 0 to 4) is linked to port q. With link-master 0, it drives port q's incoming clock and frame, with clock enable 1. With link-master 1, its clock and frame outputs are 0 and its clock enable is 0.
- R6: With the transmit flag of a data line set, a routed port drives that line from the same line of its source (controller output or the input of port q), with output enable 1. With the flag clear, the line's output and enable are 0.
- R7: Each controller receives clock and frame from its clock/frame port, and each data line from its selected port. Several controllers may select the same port.
- R8: Unused codes give low outputs. For a port, these are source codes 3 to 15 and 21 to 31: every output and enable of that port is 0. For a controller, a field code from 5 to 15 drives the signals that field routes to 0.
- R9: A write to any address other than the eight word addresses is ignored; this includes unaligned addresses. A read of such an address returns 0. Bits outside the defined fields read as 0.
- R10: A written value reaches the routing outputs right after the rising edge that samples the write strobe, not before. Read data appears after the edge that samples the read strobe and holds while the read strobe is low.
- R11: Any combination is applied as programmed, including a port linked to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| pad_clk_i | input | NUM_PORTS | Incoming bit clock per port |
| pad_fs_i | input | NUM_PORTS | Incoming frame sync per port |
| pad_d1_i | input | NUM_PORTS | Incoming data line 1 per port |
| pad_d2_i | input | NUM_PORTS | Incoming data line 2 per port |
| pad_clk_o | output | NUM_PORTS | Outgoing bit clock per port |
| pad_fs_o | output | NUM_PORTS | Outgoing frame sync per port |
| pad_clk_oe | output | NUM_PORTS | Drive enable for clock and frame |
| pad_d1_o | output | NUM_PORTS | Outgoing data line 1 |
| pad_d1_oe | output | NUM_PORTS | Drive enable, data line 1 |
| pad_d2_o | output | NUM_PORTS | Outgoing data line 2 |
| pad_d2_oe | output | NUM_PORTS | Drive enable, data line 2 |
| ctl_clk_i | input | NUM_CTRL | Bit clock from each controller |
| ctl_fs_i | input | NUM_CTRL | Frame sync from each controller |
| ctl_d1_i | input | NUM_CTRL | Data line 1 from each controller |
| ctl_d2_i | input | NUM_CTRL | Data line 2 from each controller |
| ctl_clk_o | output | NUM_CTRL | Bit clock to each controller |
| ctl_fs_o | output | NUM_CTRL | Frame sync to each controller |
| ctl_d1_o | output | NUM_CTRL | Data line 1 to each controller |
| ctl_d2_o | output | NUM_CTRL | Data line 2 to each controller |

## Verification
Routing outputs are combinational from the pad and controller inputs, so the bench changes those inputs on a falling edge and compares one time unit later, in the same cycle. A configuration write is due right after the rising edge that samples it. The bench therefore raises the strobe on a falling edge, confirms the routing is still the old one one time unit later, and compares against the updated model at the next falling edge. Read data is due one edge after the read strobe, so it is compared at the following falling edge. The rule that read data holds while the strobe is low is checked by property.

// File: rtl/audio_xbar_pkg.sv
`timescale 1ns/1ps
package audio_xbar_pkg;

    localparam int SRC_W          = 5;
    localparam int PSEL_W         = 4;
    localparam int PORT_SRC_BASE  = 16;
    localparam int SRC_NONE       = 31;
    localparam int PORT_BASE_ADDR = 'h00;
    localparam int CTRL_BASE_ADDR = 'h40;
    localparam int WORD_BYTES     = 4;
    localparam logic [31:0] PORT_MASK = 32'hE000_001F;
    localparam logic [31:0] CTRL_MASK = 32'hFF00_000F;

    typedef struct packed {
        logic              master_in;
        logic              d1_tx;
        logic              d2_tx;
        logic [SRC_W-1:0]  src;
    } port_cfg_t;

    typedef struct packed {
        logic [PSEL_W-1:0] d2_sel;
        logic [PSEL_W-1:0] d1_sel;
        logic [PSEL_W-1:0] clk_sel;
    } ctrl_cfg_t;

    function automatic port_cfg_t port_unpack(input logic [31:0] w);
        port_cfg_t r;
        r.master_in = w[31];
        r.d1_tx     = w[30];
        r.d2_tx     = w[29];
        r.src       = w[SRC_W-1:0];
        return r;
    endfunction

    function automatic logic [31:0] port_pack(input port_cfg_t c);
        return {c.master_in, c.d1_tx, c.d2_tx, 24'b0, c.src};
    endfunction

    function automatic ctrl_cfg_t ctrl_unpack(input logic [31:0] w);
        ctrl_cfg_t r;
        r.d2_sel  = w[31:28];
        r.d1_sel  = w[27:24];
        r.clk_sel = w[3:0];
        return r;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_cfg_t c);
        return {c.d2_sel, c.d1_sel, 20'b0, c.clk_sel};
    endfunction

endpackage

// File: rtl/xbar_regfile.sv
`timescale 1ns/1ps
module xbar_regfile
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTRL  = 3,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output port_cfg_t         port_cfg [NUM_PORTS],
    output ctrl_cfg_t         ctrl_cfg [NUM_CTRL]
);

    logic [31:0] rd_next;
    logic [31:0] rd_q;
    logic        wr_spare_unused;

    assign wr_spare_unused = ^wr_data[23:5];

    // Port control words (R1, R3)
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_reg
        localparam logic [ADDR_W-1:0] WADDR  = ADDR_W'(PORT_BASE_ADDR + WORD_BYTES * p);
        localparam logic [SRC_W-1:0]  RSTSRC = (p < NUM_CTRL) ? SRC_W'(p) : SRC_W'(SRC_NONE);
        port_cfg_t cfg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '{master_in: 1'b0, d1_tx: 1'b0, d2_tx: 1'b0, src: RSTSRC};
            end else if (wr_en && addr == WADDR) begin
                cfg_q <= port_unpack(wr_data);
            end
        end
        assign port_cfg[p] = cfg_q;
    end

    // Controller selection words (R2, R3)
    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl_reg
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(CTRL_BASE_ADDR + WORD_BYTES * c);
        ctrl_cfg_t cfg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (wr_en && addr == WADDR) begin
                cfg_q <= ctrl_unpack(wr_data);
            end
        end
        assign ctrl_cfg[c] = cfg_q;
    end

    // Read decode: unmatched addresses give zero (R9)
    always_comb begin
        rd_next = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == ADDR_W'(PORT_BASE_ADDR + WORD_BYTES * p)) begin
                rd_next = port_pack(port_cfg[p]);
            end
        end
        for (int c = 0; c < NUM_CTRL; c++) begin
            if (addr == ADDR_W'(CTRL_BASE_ADDR + WORD_BYTES * c)) begin
                rd_next = ctrl_pack(ctrl_cfg[c]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/xbar_port_route.sv
`timescale 1ns/1ps
module xbar_port_route
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTRL  = 3
) (
    input  port_cfg_t            cfg,
    input  logic [NUM_PORTS-1:0] pad_clk_i,
    input  logic [NUM_PORTS-1:0] pad_fs_i,
    input  logic [NUM_PORTS-1:0] pad_d1_i,
    input  logic [NUM_PORTS-1:0] pad_d2_i,
    input  logic [NUM_CTRL-1:0]  ctl_clk_i,
    input  logic [NUM_CTRL-1:0]  ctl_fs_i,
    input  logic [NUM_CTRL-1:0]  ctl_d1_i,
    input  logic [NUM_CTRL-1:0]  ctl_d2_i,
    output logic                 clk_o,
    output logic                 fs_o,
    output logic                 clk_oe,
    output logic                 d1_o,
    output logic                 d1_oe,
    output logic                 d2_o,
    output logic                 d2_oe
);

    // Unused source codes leave every output low (R8)
    always_comb begin
        clk_o  = 1'b0;
        fs_o   = 1'b0;
        clk_oe = 1'b0;
        d1_o   = 1'b0;
        d1_oe  = 1'b0;
        d2_o   = 1'b0;
        d2_oe  = 1'b0;
        // Controller as source (R4, R6)
        for (int c = 0; c < NUM_CTRL; c++) begin
            if (cfg.src == SRC_W'(c)) begin
                clk_o  = ctl_clk_i[c];
                fs_o   = ctl_fs_i[c];
                clk_oe = 1'b1;
                d1_o   = cfg.d1_tx & ctl_d1_i[c];
                d1_oe  = cfg.d1_tx;
                d2_o   = cfg.d2_tx & ctl_d2_i[c];
                d2_oe  = cfg.d2_tx;
            end
        end
        // Another port as source, self-link allowed (R5, R6, R11)
        for (int q = 0; q < NUM_PORTS; q++) begin
            if (cfg.src == SRC_W'(PORT_SRC_BASE + q)) begin
                clk_o  = ~cfg.master_in & pad_clk_i[q];
                fs_o   = ~cfg.master_in & pad_fs_i[q];
                clk_oe = ~cfg.master_in;
                d1_o   = cfg.d1_tx & pad_d1_i[q];
                d1_oe  = cfg.d1_tx;
                d2_o   = cfg.d2_tx & pad_d2_i[q];
                d2_oe  = cfg.d2_tx;
            end
        end
    end

endmodule

// File: rtl/xbar_ctrl_route.sv
`timescale 1ns/1ps
module xbar_ctrl_route
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5
) (
    input  ctrl_cfg_t            cfg,
    input  logic [NUM_PORTS-1:0] pad_clk_i,
    input  logic [NUM_PORTS-1:0] pad_fs_i,
    input  logic [NUM_PORTS-1:0] pad_d1_i,
    input  logic [NUM_PORTS-1:0] pad_d2_i,
    output logic                 clk_o,
    output logic                 fs_o,
    output logic                 d1_o,
    output logic                 d2_o
);

    // Each field picks a port independently; codes past the last port give 0 (R7, R8)
    always_comb begin
        clk_o = 1'b0;
        fs_o  = 1'b0;
        d1_o  = 1'b0;
        d2_o  = 1'b0;
        for (int q = 0; q < NUM_PORTS; q++) begin
            if (cfg.clk_sel == PSEL_W'(q)) begin
                clk_o = pad_clk_i[q];
                fs_o  = pad_fs_i[q];
            end
            if (cfg.d1_sel == PSEL_W'(q)) d1_o = pad_d1_i[q];
            if (cfg.d2_sel == PSEL_W'(q)) d2_o = pad_d2_i[q];
        end
    end

endmodule

// File: rtl/audio_xbar.sv
`timescale 1ns/1ps
module audio_xbar
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTRL  = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [31:0]          bus_wr_data,
    input  logic                 bus_rd_en,
    output logic [31:0]          bus_rd_data,
    input  logic [NUM_PORTS-1:0] pad_clk_i,
    input  logic [NUM_PORTS-1:0] pad_fs_i,
    input  logic [NUM_PORTS-1:0] pad_d1_i,
    input  logic [NUM_PORTS-1:0] pad_d2_i,
    output logic [NUM_PORTS-1:0] pad_clk_o,
    output logic [NUM_PORTS-1:0] pad_fs_o,
    output logic [NUM_PORTS-1:0] pad_clk_oe,
    output logic [NUM_PORTS-1:0] pad_d1_o,
    output logic [NUM_PORTS-1:0] pad_d1_oe,
    output logic [NUM_PORTS-1:0] pad_d2_o,
    output logic [NUM_PORTS-1:0] pad_d2_oe,
    input  logic [NUM_CTRL-1:0]  ctl_clk_i,
    input  logic [NUM_CTRL-1:0]  ctl_fs_i,
    input  logic [NUM_CTRL-1:0]  ctl_d1_i,
    input  logic [NUM_CTRL-1:0]  ctl_d2_i,
    output logic [NUM_CTRL-1:0]  ctl_clk_o,
    output logic [NUM_CTRL-1:0]  ctl_fs_o,
    output logic [NUM_CTRL-1:0]  ctl_d1_o,
    output logic [NUM_CTRL-1:0]  ctl_d2_o
);

    port_cfg_t port_cfg [NUM_PORTS];
    ctrl_cfg_t ctrl_cfg [NUM_CTRL];

    xbar_regfile #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_CTRL  (NUM_CTRL),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr_en),
        .wr_data  (bus_wr_data),
        .rd_en    (bus_rd_en),
        .rd_data  (bus_rd_data),
        .port_cfg (port_cfg),
        .ctrl_cfg (ctrl_cfg)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        xbar_port_route #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_CTRL  (NUM_CTRL)
        ) route_i (
            .cfg       (port_cfg[p]),
            .pad_clk_i (pad_clk_i),
            .pad_fs_i  (pad_fs_i),
            .pad_d1_i  (pad_d1_i),
            .pad_d2_i  (pad_d2_i),
            .ctl_clk_i (ctl_clk_i),
            .ctl_fs_i  (ctl_fs_i),
            .ctl_d1_i  (ctl_d1_i),
            .ctl_d2_i  (ctl_d2_i),
            .clk_o     (pad_clk_o[p]),
            .fs_o      (pad_fs_o[p]),
            .clk_oe    (pad_clk_oe[p]),
            .d1_o      (pad_d1_o[p]),
            .d1_oe     (pad_d1_oe[p]),
            .d2_o      (pad_d2_o[p]),
            .d2_oe     (pad_d2_oe[p])
        );
    end

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
        xbar_ctrl_route #(
            .NUM_PORTS (NUM_PORTS)
        ) route_i (
            .cfg       (ctrl_cfg[c]),
            .pad_clk_i (pad_clk_i),
            .pad_fs_i  (pad_fs_i),
            .pad_d1_i  (pad_d1_i),
            .pad_d2_i  (pad_d2_i),
            .clk_o     (ctl_clk_o[c]),
            .fs_o      (ctl_fs_o[c]),
            .d1_o      (ctl_d1_o[c]),
            .d2_o      (ctl_d2_o[c])
        );
    end

endmodule

// File: rtl/audio_xbar_chk.sv
`timescale 1ns/1ps
module audio_xbar_chk
    import audio_xbar_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_CTRL  = 3,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_rd_en,
    input logic [31:0]          bus_rd_data,
    input logic [NUM_PORTS-1:0] pad_clk_o,
    input logic [NUM_PORTS-1:0] pad_fs_o,
    input logic [NUM_PORTS-1:0] pad_clk_oe,
    input logic [NUM_PORTS-1:0] pad_d1_o,
    input logic [NUM_PORTS-1:0] pad_d1_oe,
    input logic [NUM_PORTS-1:0] pad_d2_o,
    input logic [NUM_PORTS-1:0] pad_d2_oe
);

    logic is_port_addr;
    logic is_ctrl_addr;

    always_comb begin
        is_port_addr = 1'b0;
        is_ctrl_addr = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (bus_addr == ADDR_W'(PORT_BASE_ADDR + WORD_BYTES * p)) is_port_addr = 1'b1;
        for (int c = 0; c < NUM_CTRL; c++)
            if (bus_addr == ADDR_W'(CTRL_BASE_ADDR + WORD_BYTES * c)) is_ctrl_addr = 1'b1;
    end

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rd_data));

    assert_bad_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !is_port_addr && !is_ctrl_addr) |=> bus_rd_data == 32'h0);

    assert_port_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && is_port_addr) |=> (bus_rd_data & ~PORT_MASK) == 32'h0);

    assert_ctrl_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && is_ctrl_addr) |=> (bus_rd_data & ~CTRL_MASK) == 32'h0);

    assert_undriven_d1_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_d1_o & ~pad_d1_oe) == '0);

    assert_undriven_d2_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_d2_o & ~pad_d2_oe) == '0);

    assert_undriven_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_clk_o | pad_fs_o) & ~pad_clk_oe) == '0);

endmodule

bind audio_xbar audio_xbar_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_CTRL  (NUM_CTRL),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .pad_clk_o   (pad_clk_o),
    .pad_fs_o    (pad_fs_o),
    .pad_clk_oe  (pad_clk_oe),
    .pad_d1_o    (pad_d1_o),
    .pad_d1_oe   (pad_d1_oe),
    .pad_d2_o    (pad_d2_o),
    .pad_d2_oe   (pad_d2_oe)
);

// File: tb/audio_xbar_tb_top.sv
`timescale 1ns/1ps
module audio_xbar_tb_top;

    localparam int NP = 5;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr_en = 1'b0;
    logic [31:0]   bus_wr_data = '0;
    logic          bus_rd_en = 1'b0;
    logic [31:0]   bus_rd_data;
    logic [NP-1:0] pad_clk_i = '0, pad_fs_i = '0, pad_d1_i = '0, pad_d2_i = '0;
    logic [NP-1:0] pad_clk_o, pad_fs_o, pad_clk_oe, pad_d1_o, pad_d1_oe, pad_d2_o, pad_d2_oe;
    logic [NC-1:0] ctl_clk_i = '0, ctl_fs_i = '0, ctl_d1_i = '0, ctl_d2_i = '0;
    logic [NC-1:0] ctl_clk_o, ctl_fs_o, ctl_d1_o, ctl_d2_o;

    logic [31:0] m_port [NP];
    logic [31:0] m_ctrl [NC];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    audio_xbar dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus word model: returns -1 for no port, else index
    function automatic int port_idx(input logic [7:0] a);
        for (int p = 0; p < NP; p++) if (a == 8'(4 * p)) return p;
        return -1;
    endfunction

    function automatic int ctrl_idx(input logic [7:0] a);
        for (int c = 0; c < NC; c++) if (a == 8'('h40 + 4 * c)) return c;
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (port_idx(a) >= 0) return m_port[port_idx(a)];
        if (ctrl_idx(a) >= 0) return m_ctrl[ctrl_idx(a)];
        return 32'h0;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) m_port[p] = (p < NC) ? 32'(p) : 32'd31;
        for (int c = 0; c < NC; c++) m_ctrl[c] = 32'h0;
    endtask

    task automatic randomize_inputs();
        pad_clk_i = NP'($urandom); pad_fs_i = NP'($urandom);
        pad_d1_i  = NP'($urandom); pad_d2_i = NP'($urandom);
        ctl_clk_i = NC'($urandom); ctl_fs_i = NC'($urandom);
        ctl_d1_i  = NC'($urandom); ctl_d2_i = NC'($urandom);
    endtask

    task automatic check_routes(input string tag);
        logic [NP-1:0] e_clk, e_fs, e_coe, e_d1, e_d1oe, e_d2, e_d2oe;
        logic [NC-1:0] f_clk, f_fs, f_d1, f_d2;
        e_clk = '0; e_fs = '0; e_coe = '0; e_d1 = '0; e_d1oe = '0; e_d2 = '0; e_d2oe = '0;
        f_clk = '0; f_fs = '0; f_d1 = '0; f_d2 = '0;
        for (int p = 0; p < NP; p++) begin
            int s;
            logic mi, t1, t2;
            s = int'(m_port[p][4:0]);
            mi = m_port[p][31]; t1 = m_port[p][30]; t2 = m_port[p][29];
            if (s < NC) begin
                e_clk[p] = ctl_clk_i[s]; e_fs[p] = ctl_fs_i[s]; e_coe[p] = 1'b1;
                e_d1[p] = t1 & ctl_d1_i[s]; e_d1oe[p] = t1;
                e_d2[p] = t2 & ctl_d2_i[s]; e_d2oe[p] = t2;
            end else if (s >= 16 && s < 16 + NP) begin
                e_clk[p] = !mi & pad_clk_i[s-16]; e_fs[p] = !mi & pad_fs_i[s-16];
                e_coe[p] = !mi;
                e_d1[p] = t1 & pad_d1_i[s-16]; e_d1oe[p] = t1;
                e_d2[p] = t2 & pad_d2_i[s-16]; e_d2oe[p] = t2;
            end
        end
        for (int c = 0; c < NC; c++) begin
            int cs, s1, s2;
            cs = int'(m_ctrl[c][3:0]); s1 = int'(m_ctrl[c][27:24]); s2 = int'(m_ctrl[c][31:28]);
            if (cs < NP) begin f_clk[c] = pad_clk_i[cs]; f_fs[c] = pad_fs_i[cs]; end
            if (s1 < NP) f_d1[c] = pad_d1_i[s1];
            if (s2 < NP) f_d2[c] = pad_d2_i[s2];
        end
        chk({tag, " pad_clk_o"},  32'(pad_clk_o),  32'(e_clk));
        chk({tag, " pad_fs_o"},   32'(pad_fs_o),   32'(e_fs));
        chk({tag, " pad_clk_oe"}, 32'(pad_clk_oe), 32'(e_coe));
        chk({tag, " pad_d1_o"},   32'(pad_d1_o),   32'(e_d1));
        chk({tag, " pad_d1_oe"},  32'(pad_d1_oe),  32'(e_d1oe));
        chk({tag, " pad_d2_o"},   32'(pad_d2_o),   32'(e_d2));
        chk({tag, " pad_d2_oe"},  32'(pad_d2_oe),  32'(e_d2oe));
        chk({tag, " ctl_clk_o"},  32'(ctl_clk_o),  32'(f_clk));
        chk({tag, " ctl_fs_o"},   32'(ctl_fs_o),   32'(f_fs));
        chk({tag, " ctl_d1_o"},   32'(ctl_d1_o),   32'(f_d1));
        chk({tag, " ctl_d2_o"},   32'(ctl_d2_o),   32'(f_d2));
    endtask

    // Write: strobe raised on a falling edge, sampled by the next rising edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input bit pre_check);
        @(negedge clk);
        bus_addr = a; bus_wr_en = 1'b1; bus_wr_data = d;
        if (pre_check) begin
            #1 check_routes("R10 before edge");
        end
        @(negedge clk);
        bus_wr_en = 1'b0;
        if (port_idx(a) >= 0) m_port[port_idx(a)] = d & 32'hE000_001F;
        if (ctrl_idx(a) >= 0) m_ctrl[ctrl_idx(a)] = d & 32'hFF00_000F;
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        chk(tag, bus_rd_data, model_read(a));
    endtask

    task automatic rand_check(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            randomize_inputs();
            #1 check_routes(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        randomize_inputs();
        repeat (3) @(negedge clk);
        chk("R3 rd_data reset", bus_rd_data, 32'h0);
        rand_check("R3/R8 reset routing", 4);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NP; i++) bus_read(8'(4 * i), "R3/R1 port reset word");
        for (int i = 0; i < NC; i++) bus_read(8'('h40 + 4 * i), "R3/R2 ctrl reset word");

        // Broadcast: port 1 feeds every controller (R7)
        for (int c = 0; c < NC; c++) bus_write(8'('h40 + 4 * c), 32'h1100_0001, 1'b0);
        rand_check("R7 broadcast", 6);
        bus_write(8'h44, 32'h2400_0003, 1'b0);
        rand_check("R7/R2 split fields", 4);

        // Controller-sourced ports with direction flags (R4/R6)
        bus_write(8'h00, 32'h4000_0002, 1'b0);
        bus_write(8'h04, 32'h2000_0000, 1'b0);
        rand_check("R4/R6 ctrl source", 4);

        // Port-to-port link: port 0 slave of port 3, port 3 master (R5)
        bus_write(8'h00, 32'h4000_0013, 1'b1);
        bus_write(8'h0C, 32'hA000_0010, 1'b0);
        rand_check("R5/R6 port link", 6);

        // Self link and two masters applied as written (R11)
        bus_write(8'h08, 32'h6000_0012, 1'b0);
        bus_write(8'h00, 32'h8000_0013, 1'b0);
        rand_check("R11 unchecked combo", 4);

        // Unused codes (R8)
        bus_write(8'h10, 32'hE000_0005, 1'b0);
        bus_write(8'h40, 32'h9F00_000C, 1'b0);
        rand_check("R8 unused codes", 4);

        // Out-of-range and unaligned accesses (R9)
        bus_write(8'h14, 32'hFFFF_FFFF, 1'b0);
        bus_write(8'h3C, 32'hFFFF_FFFF, 1'b0);
        bus_write(8'h4C, 32'hFFFF_FFFF, 1'b0);
        bus_write(8'h41, 32'hFFFF_FFFF, 1'b0);
        bus_write(8'h02, 32'hFFFF_FFFF, 1'b0);
        rand_check("R9 ignored writes routing", 4);
        bus_read(8'h14, "R9 read outside");
        bus_read(8'h41, "R9 read unaligned");
        bus_read(8'h40, "R9 ctrl word intact");
        bus_read(8'h00, "R9 port word intact");
        bus_write(8'h04, 32'hFFFF_FFFF, 1'b0);
        bus_read(8'h04, "R9/R1 reserved bits zero");
        bus_write(8'h48, 32'hFFFF_FFFF, 1'b0);
        bus_read(8'h48, "R9/R2 reserved bits zero");

        // Constrained random traffic (R1/R2/R10)
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            int k;
            k = int'($urandom % 10);
            if (k < 5)      a = 8'(4 * k);
            else if (k < 8) a = 8'('h40 + 4 * (k - 5));
            else            a = 8'($urandom);
            d = $urandom;
            if ($urandom % 2 == 0) d[4:0] = 5'((($urandom % 2) == 0) ? ($urandom % 3) : (16 + $urandom % 5));
            if ($urandom % 2 == 0) begin
                d[3:0] = 4'($urandom % 5); d[27:24] = 4'($urandom % 5); d[31:28] = 4'($urandom % 5);
            end
            bus_write(a, d, (i % 25) == 0);
            rand_check("R10 random routing", 2);
            if (i % 5 == 0) bus_read(8'($urandom), "R1/R2 random read");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule